// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Picker

This block lines up each upstream burst with a local bit clock. On every bit clock it takes in a vector of eight samples of the serial line, taken at eight phases spaced one eighth of a bit apart. A falling edge on the burst-reset input starts a new acquisition. The block idles for a short initialization window. It then watches an alternating preamble for a fixed number of bits and records, for each bit, where data transitions fall within the vector.

When that window closes, the block makes one decision for the whole burst. It takes the most frequent transition position and picks the sample phase half a bit away from it. From then on, that phase's sample of every vector passes through a short pipeline to a one-bit retimed output. A lock flag rises on the cycle the first valid retimed bit appears. Until then the output is forced low. The decision and the flag hold until the next falling edge of burst reset.

Top module: `bpa_phase_picker`

## Requirements
- R1: Only a falling edge of `burst_rst` starts an acquisition. The falling edge is burst_rst sampled high at one clock edge and low at the next. That next edge is called relative edge 0. A rising edge, or a level held high or low, leaves `locked` and `phase_pick` unchanged.
- R2: The sample vectors taken at relative edges 0 to INIT_CYC (default 5) have no effect on the phase decision.
- R3: The measurement window is relative edges INIT_CYC+1 to INIT_CYC+MEAS_BITS (6 to 13 by default). In each vector of the window, a transition is counted at position i (1..7) when sample i-1 differs from sample i. A transition is counted at position 0 when sample 7 of the previous clock's vector differs from sample 0 of the current vector.
- R4: Counts are summed per position over the window. The most frequent position E wins, and a tie goes to the lowest position. `phase_pick` becomes (E+4) mod 8 after relative edge INIT_CYC+MEAS_BITS+1 (14).
- R5: If no transition is counted in the window, `phase_pick` becomes 0. Lock still rises on schedule.
- R6: `locked` is low from relative edge 0 through relative edge INIT_CYC+MEAS_BITS+OUT_DLY. It rises exactly after relative edge INIT_CYC+MEAS_BITS+1+OUT_DLY (17 by default).
- R7: While `locked` is high, `data_out` after clock edge n equals bit `phase_pick` of the vector sampled at edge n-OUT_DLY (OUT_DLY defaults to 3).
- R8: While `locked` is low, `data_out` is 0.
- R9: Once high, `locked` stays high and `phase_pick` stays fixed until the next falling edge of `burst_rst`. After that edge `locked` is low.
- R10: After `rst_n` is asserted, `locked`, `data_out` and `phase_pick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, continuous |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_rst | input | 1 | Burst restart request, acts on its falling edge |
| samples | input | NPH (8) | Line samples at NPH evenly spaced phases of one bit period, index 0 earliest |
| data_out | output | 1 | Retimed serial data, 0 while unlocked |
| locked | output | 1 | High when retimed data is valid |
| phase_pick | output | log2(NPH) (3) | Sample phase chosen for the current burst |

## Verification
A miscounted transition or a seam comparison against the wrong vector shows up as a wrong `phase_pick` one clock after the window closes. Three clocks later `data_out` disagrees with the bench's pick from the delayed vector. An off-by-one in the sequencer moves the rising edge of `locked` away from relative edge 17, so it is visible within one burst. Garbage placed in the initialization window and deliberate ties in the histogram expose a window that opens early and an argmax that favours the wrong index.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_MEAS,
      ST_PICK,
      ST_FILL,
      ST_LOCK
   } bpa_state_e;

endpackage

// File: rtl/bpa_edge_scan.sv
module bpa_edge_scan #(
   parameter int NPH = 8
) (
   input  logic [NPH-1:0] samples,
   input  logic           prev_last,
   output logic [NPH-1:0] trans
);

   genvar gi;
   generate
      for (gi = 0; gi < NPH; gi++) begin : g_pos
         if (gi == 0) begin : g_seam
            assign trans[gi] = prev_last ^ samples[0];
         end else begin : g_inner
            assign trans[gi] = samples[gi-1] ^ samples[gi];
         end
      end
   endgenerate

endmodule

// File: rtl/bpa_hist.sv
module bpa_hist #(
   parameter int NPH  = 8,
   parameter int MEAS = 8,
   localparam int PW  = $clog2(NPH),
   localparam int CW  = $clog2(MEAS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           acc,
   input  logic [NPH-1:0] trans,
   output logic [PW-1:0]  edge_idx,
   output logic           any_seen
);

   logic [CW-1:0] bin [NPH];

   genvar gi;
   generate
      for (gi = 0; gi < NPH; gi++) begin : g_bin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bin[gi] <= '0;
            end else if (clr) begin
               bin[gi] <= '0;
            end else if (acc && trans[gi]) begin
               bin[gi] <= bin[gi] + CW'(1);
            end
         end
      end
   endgenerate

   always_comb begin
      logic [CW-1:0] best_cnt;
      edge_idx = '0;
      best_cnt = bin[0];
      for (int i = 1; i < NPH; i++) begin
         if (bin[i] > best_cnt) begin
            best_cnt = bin[i];
            edge_idx = PW'(i);
         end
      end
      any_seen = (best_cnt != '0);
   end

endmodule

// File: rtl/bpa_ctrl.sv
module bpa_ctrl
   import bpa_pkg::*;
#(
   parameter int INIT_CYC  = 5,
   parameter int MEAS_BITS = 8,
   parameter int OUT_DLY   = 3,
   localparam int MAXC     = (INIT_CYC > MEAS_BITS) ?
                             ((INIT_CYC > OUT_DLY) ? INIT_CYC : OUT_DLY) :
                             ((MEAS_BITS > OUT_DLY) ? MEAS_BITS : OUT_DLY),
   localparam int CNTW     = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic burst_rst,
   output logic hist_clr,
   output logic meas_en,
   output logic pick_en,
   output logic locked
);

   bpa_state_e    state;
   logic [CNTW-1:0] cnt;
   logic          brst_q;
   logic          fall;

   assign fall     = brst_q & ~burst_rst;
   assign hist_clr = fall;
   assign meas_en  = (state == ST_MEAS) && !fall;
   assign pick_en  = (state == ST_PICK) && !fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         brst_q <= 1'b0;
         locked <= 1'b0;
      end else begin
         brst_q <= burst_rst;
         if (fall) begin
            state  <= ST_INIT;
            cnt    <= '0;
            locked <= 1'b0;
         end else begin
            unique case (state)
               ST_INIT: begin
                  if (cnt == CNTW'(INIT_CYC - 1)) begin
                     state <= ST_MEAS;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + CNTW'(1);
                  end
               end
               ST_MEAS: begin
                  if (cnt == CNTW'(MEAS_BITS - 1)) begin
                     state <= ST_PICK;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + CNTW'(1);
                  end
               end
               ST_PICK: begin
                  state <= ST_FILL;
                  cnt   <= '0;
               end
               ST_FILL: begin
                  if (cnt == CNTW'(OUT_DLY - 1)) begin
                     state  <= ST_LOCK;
                     locked <= 1'b1;
                  end else begin
                     cnt <= cnt + CNTW'(1);
                  end
               end
               default: begin
                  state <= state;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/bpa_retime.sv
module bpa_retime #(
   parameter int NPH     = 8,
   parameter int OUT_DLY = 3,
   localparam int PW     = $clog2(NPH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] samples,
   input  logic           pick_en,
   input  logic [PW-1:0]  pick_phase,
   input  logic           locked,
   output logic           prev_last,
   output logic [PW-1:0]  phase_q,
   output logic           data_out
);

   logic [NPH-1:0]     tap;
   logic [OUT_DLY-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap     <= '0;
         phase_q <= '0;
      end else begin
         tap <= samples;
         if (pick_en) begin
            phase_q <= pick_phase;
         end
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < OUT_DLY; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= 1'b0;
               else        pipe[0] <= tap[phase_q];
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[gi] <= 1'b0;
               else        pipe[gi] <= pipe[gi-1];
            end
         end
      end
   endgenerate

   assign prev_last = tap[NPH-1];
   assign data_out  = locked & pipe[OUT_DLY-1];

endmodule

// File: rtl/bpa_phase_picker.sv
module bpa_phase_picker #(
   parameter int NPH       = 8,
   parameter int INIT_CYC  = 5,
   parameter int MEAS_BITS = 8,
   parameter int OUT_DLY   = 3,
   localparam int PW       = $clog2(NPH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           burst_rst,
   input  logic [NPH-1:0] samples,
   output logic           data_out,
   output logic           locked,
   output logic [PW-1:0]  phase_pick
);

   generate
      if (NPH < 2 || (NPH & (NPH - 1)) != 0) begin : g_bad_nph
         $error("NPH must be a power of two of at least 2");
      end
      if (INIT_CYC < 1 || MEAS_BITS < 1 || OUT_DLY < 1) begin : g_bad_cnt
         $error("INIT_CYC, MEAS_BITS and OUT_DLY must each be at least 1");
      end
   endgenerate

   logic           hist_clr;
   logic           meas_en;
   logic           pick_en;
   logic           prev_last;
   logic [NPH-1:0] trans;
   logic [PW-1:0]  edge_idx;
   logic           any_seen;
   logic [PW-1:0]  pick_phase;

   bpa_ctrl #(
      .INIT_CYC (INIT_CYC),
      .MEAS_BITS(MEAS_BITS),
      .OUT_DLY  (OUT_DLY)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .burst_rst(burst_rst),
      .hist_clr (hist_clr),
      .meas_en  (meas_en),
      .pick_en  (pick_en),
      .locked   (locked)
   );

   bpa_edge_scan #(.NPH(NPH)) u_scan (
      .samples  (samples),
      .prev_last(prev_last),
      .trans    (trans)
   );

   bpa_hist #(.NPH(NPH), .MEAS(MEAS_BITS)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hist_clr),
      .acc     (meas_en),
      .trans   (trans),
      .edge_idx(edge_idx),
      .any_seen(any_seen)
   );

   assign pick_phase = any_seen ? PW'(edge_idx + PW'(NPH / 2)) : '0;

   bpa_retime #(.NPH(NPH), .OUT_DLY(OUT_DLY)) u_retime (
      .clk       (clk),
      .rst_n     (rst_n),
      .samples   (samples),
      .pick_en   (pick_en),
      .pick_phase(pick_phase),
      .locked    (locked),
      .prev_last (prev_last),
      .phase_q   (phase_pick),
      .data_out  (data_out)
   );

endmodule

// File: rtl/bpa_phase_picker_chk.sv
module bpa_phase_picker_chk #(
   parameter int NPH       = 8,
   parameter int INIT_CYC  = 5,
   parameter int MEAS_BITS = 8,
   parameter int OUT_DLY   = 3,
   localparam int PW       = $clog2(NPH),
   localparam int LOCK_AT  = INIT_CYC + MEAS_BITS + 1 + OUT_DLY
) (
   input logic          clk,
   input logic          rst_n,
   input logic          burst_rst,
   input logic          data_out,
   input logic          locked,
   input logic [PW-1:0] phase_pick
);

   logic       seen_hi;
   logic       fall_c;
   logic [7:0] since;

   assign fall_c = seen_hi & ~burst_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_hi <= 1'b0;
         since   <= 8'hFF;
      end else begin
         seen_hi <= burst_rst;
         if (fall_c)              since <= 8'd1;
         else if (since != 8'hFF) since <= since + 8'd1;
      end
   end

   // R8: output blanked while not locked
   p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !data_out);

   // R9: lock persists without a falling edge
   p_hold_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !fall_c) |=> locked);

   // R9: phase fixed while locked
   p_hold_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !fall_c) |=> $stable(phase_pick));

   // R1: a falling edge drops lock
   p_fall_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_c |=> !locked);

   // R6: lock rises on the scheduled edge only
   p_lock_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (since == 8'(LOCK_AT + 1)));

endmodule

bind bpa_phase_picker bpa_phase_picker_chk #(
   .NPH      (NPH),
   .INIT_CYC (INIT_CYC),
   .MEAS_BITS(MEAS_BITS),
   .OUT_DLY  (OUT_DLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .burst_rst (burst_rst),
   .data_out  (data_out),
   .locked    (locked),
   .phase_pick(phase_pick)
);

// File: tb/tb_bpa_phase_picker.sv
module tb_bpa_phase_picker;

   localparam int CLK_PERIOD = 10;
   localparam int NPH        = 8;
   localparam int INIT_CYC   = 5;
   localparam int MEAS_BITS  = 8;
   localparam int OUT_DLY    = 3;
   localparam int PICK_AT    = INIT_CYC + MEAS_BITS + 1;
   localparam int LOCK_AT    = PICK_AT + OUT_DLY;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           burst_rst = 1'b0;
   logic [NPH-1:0] samples = '0;
   logic           data_out;
   logic           locked;
   logic [2:0]     phase_pick;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [NPH-1:0] vh [0:63];
   bit             bits [0:64];
   int             ph [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   bpa_phase_picker #(
      .NPH(NPH), .INIT_CYC(INIT_CYC), .MEAS_BITS(MEAS_BITS), .OUT_DLY(OUT_DLY)
   ) dut (
      .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst), .samples(samples),
      .data_out(data_out), .locked(locked), .phase_pick(phase_pick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NPH-1:0] mkvec(input bit prv, input bit cur, input int phi);
      logic [NPH-1:0] v;
      for (int j = 0; j < NPH; j++) v[j] = (j < phi) ? prv : cur;
      return v;
   endfunction

   function automatic int model_pick();
      int hist [NPH];
      int best;
      for (int i = 0; i < NPH; i++) hist[i] = 0;
      for (int r = INIT_CYC + 1; r <= INIT_CYC + MEAS_BITS; r++) begin
         for (int i = 0; i < NPH; i++) begin
            bit t;
            t = (i == 0) ? (vh[r-1][NPH-1] ^ vh[r][0]) : (vh[r][i-1] ^ vh[r][i]);
            if (t) hist[i]++;
         end
      end
      best = 0;
      for (int i = 1; i < NPH; i++) if (hist[i] > hist[best]) best = i;
      if (hist[best] == 0) return 0;
      return (best + NPH/2) % NPH;
   endfunction

   task automatic build_vecs();
      for (int r = 0; r < 64; r++) vh[r] = mkvec(bits[r], bits[r+1], ph[r]);
   endtask

   // alternating preamble at fixed offset, random init area and payload
   task automatic prep_alt(input int phi, input bit rand_init);
      for (int r = 0; r <= 64; r++) bits[r] = r[0];
      for (int r = 0; r < 64; r++) ph[r] = phi;
      if (rand_init) begin
         for (int r = 0; r <= INIT_CYC; r++) bits[r] = 1'($urandom);
         for (int r = 0; r < INIT_CYC; r++) ph[r] = int'($urandom % NPH);
      end
      for (int r = PICK_AT + 1; r <= 64; r++) bits[r] = 1'($urandom);
   endtask

   task automatic run_burst(input int n, input string preq);
      int  exp_sel;
      bit  was_locked;
      int  old_phase;
      exp_sel    = model_pick();
      was_locked = locked;
      old_phase  = phase_pick;
      burst_rst  = 1'b1;
      samples    = NPH'($urandom);
      repeat (2) begin
         @(posedge clk); @(negedge clk);
         // R1: rising edge and high level leave lock and phase alone
         check(locked == was_locked, "R1 lock", locked, was_locked);
         if (was_locked) check(phase_pick == 3'(old_phase), "R1 phase", phase_pick, old_phase);
         samples = NPH'($urandom);
      end
      burst_rst = 1'b0;
      samples   = vh[0];
      for (int r = 0; r < n; r++) begin
         bit exp_lock;
         bit exp_d;
         @(posedge clk); @(negedge clk);
         exp_lock = (r >= LOCK_AT);
         check(locked == exp_lock, "R6 lock timing", locked, exp_lock);
         if (exp_lock) begin
            exp_d = vh[r-OUT_DLY][exp_sel];
            check(data_out == exp_d, "R7 data", data_out, exp_d);
         end else begin
            check(data_out == 1'b0, "R8 blank", data_out, 0);
         end
         if (r >= PICK_AT) check(phase_pick == 3'(exp_sel), preq, phase_pick, exp_sel);
         if (r + 1 < n) samples = vh[r+1];
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_2024));
      repeat (3) @(negedge clk);
      // R10: reset state
      check(locked == 1'b0, "R10 lock", locked, 0);
      check(data_out == 1'b0, "R10 data", data_out, 0);
      check(phase_pick == 3'd0, "R10 phase", phase_pick, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(locked == 1'b0, "R10 lock after release", locked, 0);

      // R3 R4: offset 3 -> transition at 3 -> phase 7
      prep_alt(3, 1'b0); build_vecs();
      check(model_pick() == 7, "R4 bench model", model_pick(), 7);
      run_burst(30, "R4 offset3");

      // R3: offset 0 uses the seam between vectors -> phase 4
      prep_alt(0, 1'b0); build_vecs();
      run_burst(30, "R3 seam");

      // R4 tie 2 vs 6 -> lowest 2 -> phase 6; R2 garbage in init window at offset 5
      prep_alt(2, 1'b0);
      for (int r = INIT_CYC + 1; r <= INIT_CYC + MEAS_BITS; r++) ph[r] = (r[0]) ? 6 : 2;
      for (int r = 0; r <= INIT_CYC; r++) ph[r] = 5;
      build_vecs();
      check(model_pick() == 6, "R4 tie model", model_pick(), 6);
      run_burst(30, "R4 tie");

      // R5: no transition in the window -> phase 0
      prep_alt(4, 1'b0);
      for (int r = 0; r <= PICK_AT; r++) bits[r] = 1'b1;
      for (int r = 0; r < INIT_CYC; r++) ph[r] = 1;
      bits[0] = 1'b0;
      build_vecs();
      run_burst(30, "R5 no edge");

      // R2: init window full of transitions at offset 1, preamble at 5 -> phase 1
      prep_alt(5, 1'b0);
      for (int r = 0; r < INIT_CYC; r++) ph[r] = 1;
      build_vecs();
      run_burst(25, "R2 init ignored");

      // R9: a fresh fall before lock restarts acquisition
      prep_alt(6, 1'b1); build_vecs();
      run_burst(12, "R9 abort");
      prep_alt(1, 1'b1); build_vecs();
      run_burst(40, "R9 restart");

      // random bursts with glitches inside the window
      for (int k = 0; k < 8; k++) begin
         prep_alt(int'($urandom % NPH), 1'b1);
         build_vecs();
         for (int r = INIT_CYC + 1; r <= INIT_CYC + MEAS_BITS; r++) begin
            if ($urandom % 4 == 0) vh[r][$urandom % NPH] ^= 1'b1;
         end
         run_burst(24 + int'($urandom % 16), "R4 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule